// File: doc/BRIEF.md
# Statically Configured Lane Crossbar

This block is the switching core of a five-port circuit-switched router. Each port carries four narrow unidirectional lanes in each direction, so the switch sees 20 input lanes and 20 output lanes. A lane carries a small data word with a frame-valid flag, plus one acknowledge wire running the other way. Every output lane is bound to exactly one input lane by an entry in a small configuration table. The entry also carries an enable flag. There is no buffering and no arbitration: once a path is set up, data moves along it every cycle, and nothing can block it.

A separate narrow write port loads the table one output lane at a time. The write carries an output-lane index and an entry that holds an enable flag and a four-bit source selector. An output lane can never take data from a lane of its own port, so the selector only has to address the 16 lanes of the other four ports. Every output lane is registered. The acknowledge wire of each output lane is passed back, without a register, to the input lane that feeds it. The configuration is meant to change rarely, under the control of a system manager, while streams run for long periods.

Top module: `lane_xbar`

## Requirements
- R1: The block has 20 input lanes and 20 output lanes. Lane index k = port*4 + lane, with port in 0..4 and lane in 0..3. Lane k occupies data bits [4k+3:4k] and valid bit k of the flat buses.
- R2: For an output lane of port p with selector s, the source is lane s[1:0] of port (p + 1 + s[3:2]) mod 5. The source therefore never lies on port p.
- R3: A write with cfg_we high and cfg_addr below 20 stores cfg_entry in the entry of that output lane. Bit 4 of cfg_entry is the enable flag and bits 3:0 are the selector. A write with cfg_addr from 20 to 31 changes no entry and no output.
- R4: An enabled output lane presents, one clock after a rising edge, the data and valid that its source input held at that edge.
- R5: A disabled output lane drives zero data and zero valid.
- R6: A write sampled at clock edge k is first seen at the outputs produced by edge k+1. Outputs produced at edge k still follow the old entry.
- R7: Input acknowledge i is the OR of out_ack over every enabled output lane whose source is input i, with no register in the path. An input lane that no enabled output selects sees zero.
- R8: While rst_n is low at a clock edge, every entry becomes disabled and every output lane goes to zero.
- R9: Any number of output lanes may select the same input lane at once. Each of them copies that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 80 | Data of the 20 input lanes, 4 bits each |
| in_valid | input | 20 | Frame-valid of each input lane |
| in_ack | output | 20 | Acknowledge routed back to each input lane |
| out_data | output | 80 | Registered data of the 20 output lanes |
| out_valid | output | 20 | Registered frame-valid of each output lane |
| out_ack | input | 20 | Acknowledge arriving on each output lane |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Output lane index of the write |
| cfg_entry | input | 5 | Entry: bit 4 enable, bits 3:0 source selector |

## Verification
The bench sweeps every selector value on every output port. A design that mixes up the port-rotation rule would send a lane's data back onto its own port, or take it from the wrong neighbour. It writes to indexes 20 to 31; a design that decodes those indexes modulo the table size would overwrite a real entry. It changes entries while traffic flows, to catch a new entry applied one cycle early or late. It points all 16 eligible outputs at one input and toggles out_ack at random. This exposes acknowledge logic that keeps only one requester or lets disabled lanes through, and data paths that leak values onto disabled outputs.

// File: rtl/lane_xbar_pkg.sv
// Shared helpers for the lane crossbar.
// Assumes lane index = port * lanes_per_port + lane.
package lane_xbar_pkg;

    // Maps an output lane and its selector to the source input lane.
    // The selector skips the output's own port by rotating from port+1.
    function automatic int src_of(input int out_idx, input int sel,
                                  input int lanes, input int ports);
        int own_port;
        int src_port;
        own_port = out_idx / lanes;
        src_port = (own_port + 1 + sel / lanes) % ports;
        return src_port * lanes + (sel % lanes);
    endfunction

endpackage

// File: rtl/lane_xbar_cfg_mem.sv
// Configuration table: one enable flag and one selector per output lane.
// Assumes writes come one entry at a time. Out-of-range indexes are dropped.
module lane_xbar_cfg_mem #(
    parameter int N_OUT = 20,
    parameter int IDX_W = 5,
    parameter int SEL_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [IDX_W-1:0]       addr,
    input  logic                   wact,
    input  logic [SEL_W-1:0]       wsel,
    output logic [N_OUT-1:0]       act,
    output logic [N_OUT*SEL_W-1:0] sel
);

    // Table update: reset clears all entries, in-range writes store one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= '0;
            sel <= '0;
        end else if (we && (int'(addr) < N_OUT)) begin
            act[addr]                <= wact;
            sel[addr*SEL_W +: SEL_W] <= wsel;
        end
    end

    // R3: an in-range write lands in the addressed entry.
    assert_write_stored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (int'(addr) < N_OUT)) |=>
            (act[$past(addr)] == $past(wact)) &&
            (sel[$past(addr)*SEL_W +: SEL_W] == $past(wsel)));

    // R3: a write beyond the table leaves every entry untouched.
    assert_oob_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (int'(addr) >= N_OUT)) |=> ($stable(act) && $stable(sel)));

endmodule

// File: rtl/lane_xbar_out_lane.sv
// One output lane: selects its source input lane and registers it.
// Assumes the selector only addresses the other ports (rotation rule).
module lane_xbar_out_lane
    import lane_xbar_pkg::*;
#(
    parameter int PORTS   = 5,
    parameter int LANES   = 4,
    parameter int LANE_W  = 4,
    parameter int SEL_W   = 4,
    parameter int IDX_W   = 5,
    parameter int OUT_IDX = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PORTS*LANES*LANE_W-1:0] in_data,
    input  logic [PORTS*LANES-1:0]      in_valid,
    input  logic                        act,
    input  logic [SEL_W-1:0]            sel,
    output logic [LANE_W-1:0]           out_d,
    output logic                        out_v
);

    logic [IDX_W-1:0] src_idx;

    // Source decode: turn the selector into a global input lane index.
    always_comb begin
        src_idx = IDX_W'(src_of(OUT_IDX, int'(sel), LANES, PORTS));
    end

    // Output register: copy the source when enabled, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_d <= '0;
            out_v <= 1'b0;
        end else if (act) begin
            out_d <= in_data[src_idx*LANE_W +: LANE_W];
            out_v <= in_valid[src_idx];
        end else begin
            out_d <= '0;
            out_v <= 1'b0;
        end
    end

    // R5: a disabled lane shows zero on the next cycle.
    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (out_v == 1'b0) && (out_d == '0));

    // R4: an enabled lane shows its source's valid one cycle later.
    assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> (out_v == $past(in_valid[src_idx])));

endmodule

// File: rtl/lane_xbar_ack_route.sv
// Reverse path: each output lane's acknowledge goes back to its source input.
// Assumes several outputs may share one source (their acknowledges are ORed).
module lane_xbar_ack_route
    import lane_xbar_pkg::*;
#(
    parameter int PORTS = 5,
    parameter int LANES = 4,
    parameter int SEL_W = 4,
    parameter int IDX_W = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [PORTS*LANES-1:0]       act,
    input  logic [PORTS*LANES*SEL_W-1:0] sel,
    input  logic [PORTS*LANES-1:0]       out_ack,
    output logic [PORTS*LANES-1:0]       in_ack
);

    localparam int N_LANES = PORTS * LANES;

    // Ack merge: OR each enabled output's acknowledge into its source.
    always_comb begin
        in_ack = '0;
        for (int j = 0; j < N_LANES; j++) begin
            if (act[j] && out_ack[j]) begin
                in_ack[src_of(j, int'(sel[j*SEL_W +: SEL_W]), LANES, PORTS)] = 1'b1;
            end
        end
    end

    // R7: with no enabled output, no input sees an acknowledge.
    assert_no_stray_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |-> (in_ack == '0));

    for (genvar g = 0; g < N_LANES; g++) begin : g_ack_chk
        logic [IDX_W-1:0] chk_src;
        // Checker decode: source lane of output g under its current entry.
        always_comb chk_src = IDX_W'(src_of(g, int'(sel[g*SEL_W +: SEL_W]), LANES, PORTS));
        // R7: an enabled output's acknowledge reaches its source input.
        assert_ack_reaches_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (act[g] && out_ack[g]) |-> in_ack[chk_src]);
    end

endmodule

// File: rtl/lane_xbar.sv
// Top of the lane crossbar: configuration table, registered output lanes
// and the reverse acknowledge path. No buffering and no arbitration.
// Assumes a single clock and a rarely changing configuration.
module lane_xbar #(
    parameter int NUM_PORTS      = 5,
    parameter int LANES_PER_PORT = 4,
    parameter int LANE_W         = 4,
    parameter int N_LANES        = NUM_PORTS * LANES_PER_PORT,
    parameter int IDX_W          = $clog2(N_LANES),
    parameter int SEL_W          = $clog2((NUM_PORTS - 1) * LANES_PER_PORT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_LANES*LANE_W-1:0] in_data,
    input  logic [N_LANES-1:0]        in_valid,
    output logic [N_LANES-1:0]        in_ack,
    output logic [N_LANES*LANE_W-1:0] out_data,
    output logic [N_LANES-1:0]        out_valid,
    input  logic [N_LANES-1:0]        out_ack,
    input  logic                      cfg_we,
    input  logic [IDX_W-1:0]          cfg_addr,
    input  logic [SEL_W:0]            cfg_entry
);

    logic [N_LANES-1:0]       tbl_act;
    logic [N_LANES*SEL_W-1:0] tbl_sel;

    lane_xbar_cfg_mem #(
        .N_OUT (N_LANES),
        .IDX_W (IDX_W),
        .SEL_W (SEL_W)
    ) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wact  (cfg_entry[SEL_W]),
        .wsel  (cfg_entry[SEL_W-1:0]),
        .act   (tbl_act),
        .sel   (tbl_sel)
    );

    for (genvar j = 0; j < N_LANES; j++) begin : g_out
        lane_xbar_out_lane #(
            .PORTS   (NUM_PORTS),
            .LANES   (LANES_PER_PORT),
            .LANE_W  (LANE_W),
            .SEL_W   (SEL_W),
            .IDX_W   (IDX_W),
            .OUT_IDX (j)
        ) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_data  (in_data),
            .in_valid (in_valid),
            .act      (tbl_act[j]),
            .sel      (tbl_sel[j*SEL_W +: SEL_W]),
            .out_d    (out_data[j*LANE_W +: LANE_W]),
            .out_v    (out_valid[j])
        );
    end

    lane_xbar_ack_route #(
        .PORTS (NUM_PORTS),
        .LANES (LANES_PER_PORT),
        .SEL_W (SEL_W),
        .IDX_W (IDX_W)
    ) ack_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (tbl_act),
        .sel     (tbl_sel),
        .out_ack (out_ack),
        .in_ack  (in_ack)
    );

    // R8: the cycle after a reset edge every output lane is idle.
    assert_reset_idle_R8: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> (out_valid == '0) && (out_data == '0));

endmodule

// File: tb/lane_xbar_tb_top.sv
// Self-checking bench: a behavioural model of the table and output lanes,
// compared with the design on every clock.
module lane_xbar_tb_top;

    localparam int P = 5;
    localparam int L = 4;
    localparam int W = 4;
    localparam int N = P * L;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N*W-1:0] in_data = '0;
    logic [N-1:0]   in_valid = '0;
    logic [N-1:0]   in_ack;
    logic [N*W-1:0] out_data;
    logic [N-1:0]   out_valid;
    logic [N-1:0]   out_ack = '0;
    logic           cfg_we = 1'b0;
    logic [4:0]     cfg_addr = '0;
    logic [4:0]     cfg_entry = '0;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R8";
    bit    done = 1'b0;

    // Model state.
    int m_act[N];
    int m_sel[N];
    int m_d[N];
    int m_v[N];

    always #2 clk = ~clk;

    lane_xbar dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ack    (in_ack),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ack   (out_ack),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_entry (cfg_entry)
    );

    // Source rule from R2, written out for the model.
    function automatic int model_src(int j, int s);
        return ((j / L + 1 + s / L) % P) * L + (s % L);
    endfunction

    initial begin
        for (int j = 0; j < N; j++) begin
            m_act[j] = 0; m_sel[j] = 0; m_d[j] = 0; m_v[j] = 0;
        end
    end

    // Model update: outputs use the old table, then the write is applied.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < N; j++) begin
                m_act[j] = 0; m_sel[j] = 0; m_d[j] = 0; m_v[j] = 0;
            end
        end else begin
            for (int j = 0; j < N; j++) begin
                if (m_act[j] != 0) begin
                    m_d[j] = int'(in_data[model_src(j, m_sel[j])*W +: W]);
                    m_v[j] = int'(in_valid[model_src(j, m_sel[j])]);
                end else begin
                    m_d[j] = 0; m_v[j] = 0;
                end
            end
            if (cfg_we && cfg_addr < 5'(N)) begin
                m_act[cfg_addr] = int'(cfg_entry[4]);
                m_sel[cfg_addr] = int'(cfg_entry[3:0]);
            end
        end
    end

    task automatic chk(input bit ok, input string what, input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: got %0d expected %0d", cur_req, what, got, exp);
        end
    endtask

    task automatic check_outputs();
        for (int j = 0; j < N; j++) begin
            chk(int'(out_data[j*W +: W]) == m_d[j], $sformatf("data lane %0d", j),
                int'(out_data[j*W +: W]), m_d[j]);
            chk(int'(out_valid[j]) == m_v[j], $sformatf("valid lane %0d", j),
                int'(out_valid[j]), m_v[j]);
        end
    endtask

    task automatic check_acks();
        int exp_ack[N];
        for (int i = 0; i < N; i++) exp_ack[i] = 0;
        for (int j = 0; j < N; j++)
            if (m_act[j] != 0 && out_ack[j]) exp_ack[model_src(j, m_sel[j])] = 1;
        for (int i = 0; i < N; i++)
            chk(int'(in_ack[i]) == exp_ack[i], $sformatf("R7 ack input %0d", i),
                int'(in_ack[i]), exp_ack[i]);
    endtask

    // One cycle: check at the falling edge, drive new stimulus, check acks.
    task automatic step(input bit we, input int addr, input int entry);
        @(negedge clk);
        check_outputs();
        in_data   = {$urandom, $urandom, $urandom};
        in_valid  = N'($urandom);
        out_ack   = N'($urandom);
        cfg_we    = we;
        cfg_addr  = 5'(addr);
        cfg_entry = 5'(entry);
        #1;
        check_acks();
    endtask

    initial begin
        // R8: reset clears table and outputs.
        cur_req = "R8";
        rst_n = 1'b0;
        repeat (3) step(1'b0, 0, 0);
        rst_n = 1'b1;
        repeat (4) step(1'b0, 0, 0);

        // R5: nothing enabled, traffic must not leak out.
        cur_req = "R5";
        repeat (6) step(1'b0, 0, 0);

        // R1, R2, R4, R6: every output enabled, selectors swept.
        for (int pass = 0; pass < 4; pass++) begin
            cur_req = "R2/R4/R6/R1";
            for (int j = 0; j < N; j++) step(1'b1, j, 16 | ((j + pass * 5) % 16));
            repeat (8) step(1'b0, 0, 0);
        end

        // R3: writes beyond the table must change nothing.
        cur_req = "R3";
        for (int a = N; a < 32; a++) step(1'b1, a, int'($urandom % 32));
        repeat (4) step(1'b0, 0, 0);

        // R9 and R7: all eligible outputs pick input lane 0.
        cur_req = "R9/R7";
        for (int j = L; j < N; j++) step(1'b1, j, 16 | ((P - 1 - j / L) * L));
        repeat (16) step(1'b0, 0, 0);

        // R5: disable the even outputs.
        cur_req = "R5";
        for (int j = 0; j < N; j += 2) step(1'b1, j, int'($urandom % 16));
        repeat (8) step(1'b0, 0, 0);

        // R6 and R3: random reconfiguration under random traffic.
        cur_req = "R6/R3";
        repeat (300) step(1'($urandom % 2), int'($urandom % 32), int'($urandom % 32));

        // R8: reset mid-traffic clears everything.
        cur_req = "R8";
        rst_n = 1'b0;
        repeat (2) step(1'b0, 0, 0);
        rst_n = 1'b1;
        repeat (4) step(1'b0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog %s: got %0d expected %0d", cur_req, 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule